// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is one group of a latched parallel port with a two-wire handshake toward a peripheral. A direction input picks between strobed input and strobed output. In input direction, the peripheral pulls an active-low strobe. While the strobe is low, the pin bus is captured into an input latch and a buffer-full flag rises. The CPU later reads the latch, and the flag drops when the read ends. In output direction, a CPU write latches the data bus onto the pins and drives an active-low output-buffer-full flag. The peripheral answers with an active-low acknowledge, which releases that flag.

A single interrupt request covers both directions. An internal request flag is set when the peripheral completes its half of the handshake: the strobe returns high with data pending, or the acknowledge returns high. The flag is cleared when the CPU starts its next access. The interrupt pin is the AND of this flag with an enable input, and the enable is held elsewhere. The handshake wires occupy fixed bit positions of an 8-bit control port. Those positions depend on whether the instance serves the first or the second group. All inputs are sampled on the clock, and edges are found by comparing each input with its value one cycle earlier.

Top module: `hsport_group`

## Requirements
- R1: While `rst` is high and in the cycle after it falls: `ibf`=0, `obfN`=1, `intr`=0, `cpuDataOut`=0 and `pinOut`=0.
- R2: In input direction (`dirIsOut`=0), every clock edge that samples the strobe low loads `pinIn` into the input latch (shown on `cpuDataOut`) and sets `ibf`. A strobe held low keeps following the pins.
- R3: In input direction, a rising edge of `cpuRdN` clears `ibf`. If the strobe is low in that same cycle, the strobe wins and `ibf` stays 1.
- R4: In input direction, the request flag sets when the strobe goes from low to high while `ibf` is 1. It clears on a falling edge of `cpuRdN`.
- R5: In output direction (`dirIsOut`=1), each edge that samples `cpuWrN` low loads `cpuDataIn` into the output latch (shown on `pinOut`). The rising edge of `cpuWrN` drives `obfN` to 0.
- R6: In output direction, a falling edge of the acknowledge drives `obfN` back to 1.
- R7: In output direction, a rising edge of the acknowledge sets the request flag. A falling edge of `cpuWrN` clears it.
- R8: `intr` equals the request flag AND `intEnable`. A flag set while the enable is 0 shows on `intr` once the enable goes to 1.
- R9: A change of `dirIsOut` clears `ibf`, the request flag and the output latch, and sets `obfN` to 1. The input latch keeps its value.
- R10: The handshake of the direction not selected has no effect. Writes in input direction leave `pinOut` and `obfN` unchanged. A low strobe in output direction leaves `ibf` at 0.
- R11: With `GROUP_A`=1, the interrupt is `pcOut[3]`, the strobe is `pcIn[4]`, input buffer-full is `pcOut[5]`, output buffer-full is `pcOut[7]` and the acknowledge is `pcIn[6]`. With `GROUP_A`=0, the interrupt is bit 0, the buffer-full flag is bit 1 and the strobe or acknowledge is bit 2. `pcOe` is 1 exactly on the two driven output bits of the current direction.
- R12: `pinOe` equals `dirIsOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuRdN | input | 1 | CPU read strobe, active low |
| cpuWrN | input | 1 | CPU write strobe, active low |
| cpuDataIn | input | WIDTH | CPU write data |
| cpuDataOut | output | WIDTH | Input latch contents for CPU reads |
| dirIsOut | input | 1 | 1 selects strobed output, 0 strobed input |
| intEnable | input | 1 | Interrupt enable |
| pinIn | input | WIDTH | Peripheral data pins, input side |
| pinOut | output | WIDTH | Peripheral data pins, output side |
| pinOe | output | 1 | Data pin output enable |
| pcIn | input | 8 | Control port pins, input side (strobe / acknowledge) |
| pcOut | output | 8 | Control port pins, output side (flags, interrupt) |
| pcOe | output | 8 | Control port per-bit output enable |
| ibf | output | 1 | Input buffer full, active high |
| obfN | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a request flag that is pending while the enable is off. The flag has to be set with the enable low, then left untouched until the enable rises, with no CPU access in between that would clear it. The stimulus completes a strobe with the enable low and checks that `intr` stays 0. It then raises only the enable on an idle cycle and expects `intr` at once. A second hard case is overlapping priority, where the strobe is still low while a read ends. A directed sequence covers it by holding the strobe low through a whole read.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
  localparam int PC_W = 8;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
    logic clearOut;
  } hsStrobes_t;
endpackage

// File: rtl/hsport_ctrl.sv
module hsport_ctrl
  import hsport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dirIsOut,
  input  logic       cpuRdN,
  input  logic       cpuWrN,
  input  logic       stbN,
  input  logic       ackN,
  input  logic       intEnable,
  output logic       ibf,
  output logic       obfN,
  output logic       intr,
  output hsStrobes_t strobes
);
  logic rdPrev, wrPrev, stbPrev, ackPrev, dirPrev;
  logic intrFlag;
  logic modeChange, inMode, outMode;
  logic rdRise, rdFall, wrRise, wrFall, stbRise, ackFall, ackRise;

  always_comb begin
    modeChange = dirIsOut ^ dirPrev;
    inMode     = !dirIsOut && !modeChange;
    outMode    = dirIsOut && !modeChange;
    rdRise     = cpuRdN & ~rdPrev;
    rdFall     = ~cpuRdN & rdPrev;
    wrRise     = cpuWrN & ~wrPrev;
    wrFall     = ~cpuWrN & wrPrev;
    stbRise    = stbN & ~stbPrev;
    ackFall    = ~ackN & ackPrev;
    ackRise    = ackN & ~ackPrev;
    strobes.loadIn   = inMode & ~stbN;
    strobes.loadOut  = outMode & ~cpuWrN;
    strobes.clearOut = modeChange;
  end

  always_ff @(posedge clk) begin
    rdPrev  <= cpuRdN;
    wrPrev  <= cpuWrN;
    stbPrev <= stbN;
    ackPrev <= ackN;
    dirPrev <= dirIsOut;
    if (rst) begin
      ibf      <= 1'b0;
      obfN     <= 1'b1;
      intrFlag <= 1'b0;
    end else if (modeChange) begin
      ibf      <= 1'b0;
      obfN     <= 1'b1;
      intrFlag <= 1'b0;
    end else if (inMode) begin
      if (!stbN)       ibf <= 1'b1;
      else if (rdRise) ibf <= 1'b0;
      if (rdFall)                intrFlag <= 1'b0;
      else if (stbRise && ibf)   intrFlag <= 1'b1;
    end else if (outMode) begin
      if (ackFall)     obfN <= 1'b1;
      else if (wrRise) obfN <= 1'b0;
      if (wrFall)       intrFlag <= 1'b0;
      else if (ackRise) intrFlag <= 1'b1;
    end
  end

  assign intr = intrFlag & intEnable;

  a_r2_strobe_sets_ibf: assert property (@(posedge clk) disable iff (rst)
    (!dirIsOut && $stable(dirIsOut) && !stbN) |=> ibf);

  a_r3_read_clears_ibf: assert property (@(posedge clk) disable iff (rst)
    (!dirIsOut && $stable(dirIsOut) && cpuRdN && !$past(cpuRdN) && stbN) |=> !ibf);

  a_r5_write_sets_obf: assert property (@(posedge clk) disable iff (rst)
    (dirIsOut && $stable(dirIsOut) && cpuWrN && !$past(cpuWrN) && ackN && $past(ackN))
    |=> !obfN);

  a_r6_ack_clears_obf: assert property (@(posedge clk) disable iff (rst)
    (dirIsOut && $stable(dirIsOut) && !ackN && $past(ackN)) |=> obfN);

  a_r9_mode_change_clears: assert property (@(posedge clk) disable iff (rst)
    !$stable(dirIsOut) |=> (!ibf && obfN && !intr));
endmodule

// File: rtl/hsport_datapath.sv
module hsport_datapath
  import hsport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  hsStrobes_t       strobes,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] cpuDataIn,
  output logic [WIDTH-1:0] inLatch,
  output logic [WIDTH-1:0] outLatch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inLatch  <= '0;
      outLatch <= '0;
    end else begin
      if (strobes.loadIn) inLatch <= pinIn;
      if (strobes.clearOut)     outLatch <= '0;
      else if (strobes.loadOut) outLatch <= cpuDataIn;
    end
  end

  a_r10_no_cross_load: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadIn && strobes.loadOut));
endmodule

// File: rtl/hsport_group.sv
module hsport_group
  import hsport_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit GROUP_A = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpuRdN,
  input  logic             cpuWrN,
  input  logic [WIDTH-1:0] cpuDataIn,
  output logic [WIDTH-1:0] cpuDataOut,
  input  logic             dirIsOut,
  input  logic             intEnable,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic             pinOe,
  input  logic [PC_W-1:0]  pcIn,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  pcOe,
  output logic             ibf,
  output logic             obfN,
  output logic             intr
);
  localparam int INTR_POS = GROUP_A ? 3 : 0;
  localparam int IBF_POS  = GROUP_A ? 5 : 1;
  localparam int OBF_POS  = GROUP_A ? 7 : 1;
  localparam int STB_POS  = GROUP_A ? 4 : 2;
  localparam int ACK_POS  = GROUP_A ? 6 : 2;

  hsStrobes_t strobes;
  logic       stbN, ackN;

  assign stbN  = pcIn[STB_POS];
  assign ackN  = pcIn[ACK_POS];
  assign pinOe = dirIsOut;

  hsport_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dirIsOut  (dirIsOut),
    .cpuRdN    (cpuRdN),
    .cpuWrN    (cpuWrN),
    .stbN      (stbN),
    .ackN      (ackN),
    .intEnable (intEnable),
    .ibf       (ibf),
    .obfN      (obfN),
    .intr      (intr),
    .strobes   (strobes)
  );

  hsport_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .pinIn     (pinIn),
    .cpuDataIn (cpuDataIn),
    .inLatch   (cpuDataOut),
    .outLatch  (pinOut)
  );

  always_comb begin
    pcOut = '0;
    pcOe  = '0;
    pcOut[INTR_POS] = intr;
    pcOe[INTR_POS]  = 1'b1;
    if (dirIsOut) begin
      pcOut[OBF_POS] = obfN;
      pcOe[OBF_POS]  = 1'b1;
    end else begin
      pcOut[IBF_POS] = ibf;
      pcOe[IBF_POS]  = 1'b1;
    end
  end
endmodule

// File: tb/test_hsport_group.sv
module test_hsport_group;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpuRdN, cpuWrN, dirIsOut, intEnable;
  logic [7:0] cpuDataIn, cpuDataOut, pinIn, pinOut;
  logic       pinOe;
  logic [7:0] pcIn, pcOut, pcOe;
  logic       ibf, obfN, intr;
  logic       stbN, ackN;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         done    = 1'b0;

  always #10 clk = ~clk;

  // group A: strobe on bit 4, acknowledge on bit 6 (R11)
  always_comb begin
    pcIn    = 8'hFF;
    pcIn[4] = stbN;
    pcIn[6] = ackN;
  end

  hsport_group i_hsport_group (
    .clk(clk), .rst(rst), .cpuRdN(cpuRdN), .cpuWrN(cpuWrN),
    .cpuDataIn(cpuDataIn), .cpuDataOut(cpuDataOut), .dirIsOut(dirIsOut),
    .intEnable(intEnable), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe), .ibf(ibf), .obfN(obfN), .intr(intr)
  );

  // [40]rd [39]wr [38]dir [37]en [36]stb [35]ack [34:27]data [26:19]pin
  // [18]ibf [17]obfN [16]intr [15:8]cpuDataOut [7:0]pinOut
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {6'b110111, 8'h00, 8'h00, 3'b010, 8'h00, 8'h00}, // R1 idle
    {6'b110101, 8'h00, 8'hA5, 3'b110, 8'hA5, 8'h00}, // R2 strobe low
    {6'b110111, 8'h00, 8'h3C, 3'b111, 8'hA5, 8'h00}, // R4 strobe rises
    {6'b010111, 8'h00, 8'h3C, 3'b110, 8'hA5, 8'h00}, // R4 read falls
    {6'b110111, 8'h00, 8'h3C, 3'b010, 8'hA5, 8'h00}, // R3 read rises
    {6'b110001, 8'h00, 8'h5A, 3'b110, 8'h5A, 8'h00}, // R2 enable off
    {6'b110011, 8'h00, 8'h00, 3'b110, 8'h5A, 8'h00}, // R8 flag hidden
    {6'b110111, 8'h00, 8'h00, 3'b111, 8'h5A, 8'h00}, // R8 enable on
    {6'b111111, 8'h00, 8'h00, 3'b010, 8'h5A, 8'h00}, // R9 to output
    {6'b101111, 8'hC3, 8'h00, 3'b010, 8'h5A, 8'hC3}, // R5 write low
    {6'b111111, 8'hC3, 8'h00, 3'b000, 8'h5A, 8'hC3}, // R5 write rises
    {6'b111110, 8'h00, 8'h00, 3'b010, 8'h5A, 8'hC3}, // R6 ack low
    {6'b111111, 8'h00, 8'h00, 3'b011, 8'h5A, 8'hC3}, // R7 ack rises
    {6'b101111, 8'h7E, 8'h00, 3'b010, 8'h5A, 8'h7E}, // R7 write clears
    {6'b111111, 8'h7E, 8'h00, 3'b000, 8'h5A, 8'h7E}, // R5 second write
    {6'b110111, 8'h00, 8'h00, 3'b010, 8'h5A, 8'h00}  // R9 to input
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpuRdN = 1'b1; cpuWrN = 1'b1; stbN = 1'b1; ackN = 1'b1;
  endtask

  task automatic checkReset(input string req);
    chk(req, {7'd0, ibf}, 8'h00);
    chk(req, {7'd0, obfN}, 8'h01);
    chk(req, {7'd0, intr}, 8'h00);
    chk(req, cpuDataOut, 8'h00);
    chk(req, pinOut, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dirIsOut = 1'b0; intEnable = 1'b1;
    cpuDataIn = 8'h00; pinIn = 8'h00;
    idle();
    @(negedge clk);
    cyc(); cyc();
    checkReset("R1 in reset");
    rst = 1'b0;
    cyc();
    checkReset("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      {cpuRdN, cpuWrN, dirIsOut, intEnable, stbN, ackN} = VEC[i][40:35];
      cpuDataIn = VEC[i][34:27];
      pinIn     = VEC[i][26:19];
      cyc();
      chk($sformatf("vec %0d ibf", i),  {7'd0, ibf},  {7'd0, VEC[i][18]});
      chk($sformatf("vec %0d obfN", i), {7'd0, obfN}, {7'd0, VEC[i][17]});
      chk($sformatf("vec %0d intr", i), {7'd0, intr}, {7'd0, VEC[i][16]});
      chk($sformatf("vec %0d cpuDataOut", i), cpuDataOut, VEC[i][15:8]);
      chk($sformatf("vec %0d pinOut", i), pinOut, VEC[i][7:0]);
    end

    // R2: strobe held low keeps following the pins
    idle(); dirIsOut = 1'b0;
    stbN = 1'b0; pinIn = 8'h11; cyc();
    pinIn = 8'h22; cyc();
    chk("R2 held strobe tracks", cpuDataOut, 8'h22);
    // R3: read ending while strobe low leaves ibf set
    cpuRdN = 1'b0; cyc();
    cpuRdN = 1'b1; cyc();
    chk("R3 strobe wins over read", {7'd0, ibf}, 8'h01);
    stbN = 1'b1; cyc();
    cpuRdN = 1'b0; cyc();
    chk("R4 read fall clears intr", {7'd0, intr}, 8'h00);
    cpuRdN = 1'b1; cyc();
    chk("R3 read rise clears ibf", {7'd0, ibf}, 8'h00);

    // R10: write in input direction ignored
    cpuDataIn = 8'h99; cpuWrN = 1'b0; cyc();
    cpuWrN = 1'b1; cyc();
    chk("R10 write ignored pinOut", pinOut, 8'h00);
    chk("R10 write ignored obfN", {7'd0, obfN}, 8'h01);
    // R11 / R12 input direction mapping
    chk("R11 pcOe input", pcOe, 8'h28);
    chk("R12 pinOe input", {7'd0, pinOe}, 8'h00);
    stbN = 1'b0; cyc();
    chk("R11 ibf on pcOut5", pcOut & 8'h28, 8'h20);
    stbN = 1'b1; cyc();
    chk("R11 intr on pcOut3", pcOut & 8'h28, 8'h28);
    cpuRdN = 1'b0; cyc();
    cpuRdN = 1'b1; cyc();

    // output direction
    dirIsOut = 1'b1; cyc();
    chk("R11 pcOe output", pcOe, 8'h88);
    chk("R12 pinOe output", {7'd0, pinOe}, 8'h01);
    stbN = 1'b0; cyc();
    chk("R10 strobe ignored ibf", {7'd0, ibf}, 8'h00);
    stbN = 1'b1;
    cpuDataIn = 8'hAA; cpuWrN = 1'b0; cyc();
    cpuWrN = 1'b1; cyc();
    chk("R11 obfN on pcOut7", pcOut & 8'h88, 8'h00);
    chk("R5 write data", pinOut, 8'hAA);
    ackN = 1'b0; cyc();
    chk("R11 obfN high on pcOut7", pcOut & 8'h88, 8'h80);

    // R1: reset from a dirty state
    rst = 1'b1; idle(); cyc(); cyc();
    checkReset("R1 second reset");
    rst = 1'b0; cyc();
    checkReset("R1 after second reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule